// File: doc/BRIEF.md
# Flash Write-Completion Status Poller

This block runs on the host side of a byte-wide parallel flash device. After software or a sequencer has finished sending a program or erase command sequence, a single `start` pulse hands the poller the target address, the byte that was programmed and the kind of operation. The poller then reads that address again and again through a simple request/response read port until the device reports that its internal operation has finished. It ends with a one-cycle `done` pulse and a held pass/fail/timeout result.

Two status methods are supported, selected per run. In the inverted-MSB method, bit 7 of a read shows the inverse of the programmed bit 7 while a program is running, or 0 while an erase is running. In the toggle method, bit 6 flips on every read while the device is busy. The device finishes asynchronously, so a status read can land in the middle of the transition. For that reason any read that seems to say "busy" is followed by two confirming reads before it is believed. Once completion is accepted, the poller waits a settling interval (1 µs, given in clock cycles), and for a program it then reads the whole byte once more and compares it with the expected value. A poll-round limit raises a timeout if the device never finishes.

Top module: `flash_status_poller`

## Requirements
- R1: `start` is accepted only while the poller is idle. The address, expected byte, operation type (`opErase`: 0 program, 1 erase) and method (`useToggle`: 0 inverted-MSB, 1 toggle) are captured at that edge. A `start` pulse during a run has no effect on that run's reads or result.
- R2: At most one read is outstanding. `rdReq` stays high with a stable `rdAddr` equal to the captured address until a cycle with `rdValid` high, and `rdData` is taken in that cycle.
- R3: In inverted-MSB mode for a program, a read shows completion when its bit 7 equals bit 7 of the expected byte.
- R4: In inverted-MSB mode for an erase, a read shows completion when its bit 7 is 1.
- R5: In toggle mode, a read shows completion when its bit 6 equals bit 6 of the read just before it in the same run. The first read after `start` has no predecessor and never shows completion.
- R6: A read that does not show completion starts a confirmation: two more reads of the same address follow. If both show completion, the operation is complete. Otherwise the rejection stands and a new poll round begins. A poll round that shows completion on its first read is accepted at once.
- R7: After completion is accepted, `SETTLE_CYCLES` cycles pass before the verify read is requested. The `rdReq` of the verify read rises exactly `SETTLE_CYCLES`+2 cycles after the cycle of the last status read's `rdValid`.
- R8: For a program, one verify read compares all 8 bits with the expected byte: pass if equal, fail otherwise. For an erase, the result is pass after the settle interval, with no verify read.
- R9: If the rejection stands in poll round number `POLL_LIMIT`, the run ends with `timeout` and `fail` high and `pass` low.
- R10: `done` is high for exactly one cycle per run, and in that cycle exactly one of `pass`/`fail` is high. `pass`, `fail` and `timeout` then hold until the next accepted `start`, which clears them.
- R11: During and after reset the poller is idle with `rdReq`, `done`, `pass`, `fail` and `timeout` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin polling |
| opErase | input | 1 | Operation type: 0 program, 1 erase |
| useToggle | input | 1 | Method: 0 inverted bit 7, 1 toggling bit 6 |
| addrIn | input | ADDR_W | Address to poll |
| dataIn | input | 8 | Byte that was programmed |
| rdReq | output | 1 | Read request, held until answered |
| rdAddr | output | ADDR_W | Read address |
| rdValid | input | 1 | Read answer strobe |
| rdData | input | 8 | Read data, valid with rdValid |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Operation completed and verified |
| fail | output | 1 | Verify mismatch or timeout |
| timeout | output | 1 | Poll-round limit reached |

## Verification
The bound properties assume that the read responder answers only while `rdReq` is high, with at most one `rdValid` pulse per request, and that `start` is a single-cycle pulse. The bench's device model is written to respect exactly that. It answers each request after a fixed latency and drops `rdValid` on the next cycle. It produces busy bytes whose bit 7 and bit 6 follow the status rules up to a chosen read index. It garbles only the low six bits of status reads taken after completion, so those garbled bits never reach a status decision and show up only if the verify read were skipped or reused.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_CONF1,
    ST_CONF2,
    ST_SETTLE,
    ST_VERIFY,
    ST_DONE
  } pollState_t;

  typedef enum logic [1:0] {
    PH_MAIN,
    PH_CONF1,
    PH_CONF2
  } pollPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic capture;
    logic pollStep;
    logic settleClr;
    logic setPass;
    logic setFail;
    logic setTimeout;
  } pollStrobe_t;

endpackage

// File: rtl/poll_datapath.sv
module poll_datapath
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int POLL_LIMIT    = 4096,
  parameter int SETTLE_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobe_t       stb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  logic              opErase,
  input  logic              useToggle,
  input  logic [7:0]        rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              ok,
  output logic              verifyMatch,
  output logic              pollAtLimit,
  output logic              settleDone,
  output logic              isErase,
  output logic              pass,
  output logic              fail,
  output logic              timeout
);

  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [PW-1:0] POLL_LAST   = PW'(POLL_LIMIT);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES - 1);

  logic [7:0]    expByte;
  logic          toggleMode;
  logic [7:0]    rdByte;
  logic          prevBit6;
  logic          haveAny;
  logic          havePrev;
  logic [PW-1:0] pollCnt;
  logic [SW-1:0] settleCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddr     <= '0;
      expByte    <= '0;
      isErase    <= 1'b0;
      toggleMode <= 1'b0;
    end else if (stb.load) begin
      rdAddr     <= addrIn;
      expByte    <= dataIn;
      isErase    <= opErase;
      toggleMode <= useToggle;
    end
  end

  // latest status byte plus bit 6 of the read before it
  always_ff @(posedge clk) begin
    if (!rstN || stb.load) begin
      rdByte   <= '0;
      prevBit6 <= 1'b0;
      haveAny  <= 1'b0;
      havePrev <= 1'b0;
    end else if (stb.capture) begin
      rdByte   <= rdData;
      prevBit6 <= rdByte[6];
      havePrev <= haveAny;
      haveAny  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.load)  pollCnt <= '0;
    else if (stb.pollStep)  pollCnt <= pollCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.settleClr) settleCnt <= '0;
    else if (!settleDone)       settleCnt <= settleCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.load) begin
      pass    <= 1'b0;
      fail    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      if (stb.setPass)    pass    <= 1'b1;
      if (stb.setFail)    fail    <= 1'b1;
      if (stb.setTimeout) timeout <= 1'b1;
    end
  end

  logic msbOk;
  logic toggleOk;

  always_comb begin
    msbOk       = isErase ? rdByte[7] : (rdByte[7] == expByte[7]);
    toggleOk    = havePrev && (rdByte[6] == prevBit6);
    ok          = toggleMode ? toggleOk : msbOk;
    verifyMatch = (rdData == expByte);
    pollAtLimit = (pollCnt == POLL_LAST);
    settleDone  = (settleCnt == SETTLE_LAST);
  end

endmodule

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import flash_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        rdValid,
  input  logic        ok,
  input  logic        verifyMatch,
  input  logic        pollAtLimit,
  input  logic        settleDone,
  input  logic        isErase,
  output pollStrobe_t stb,
  output logic        rdReq,
  output logic        done
);

  pollState_t state, nxt;
  pollPhase_t phase;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  // remembers which read fed the current evaluation
  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_MAIN;
    else if (rdValid) begin
      case (state)
        ST_READ:  phase <= PH_MAIN;
        ST_CONF1: phase <= PH_CONF1;
        ST_CONF2: phase <= PH_CONF2;
        default:  phase <= phase;
      endcase
    end
  end

  always_comb begin
    nxt = state;
    stb = '0;
    case (state)
      ST_IDLE: if (start) begin
        stb.load = 1'b1;
        nxt      = ST_READ;
      end
      ST_READ: if (rdValid) begin
        stb.capture  = 1'b1;
        stb.pollStep = 1'b1;
        nxt          = ST_EVAL;
      end
      ST_CONF1, ST_CONF2: if (rdValid) begin
        stb.capture = 1'b1;
        nxt         = ST_EVAL;
      end
      ST_EVAL: begin
        if (ok) begin
          if (phase == PH_CONF1) nxt = ST_CONF2;
          else begin
            stb.settleClr = 1'b1;
            nxt           = ST_SETTLE;
          end
        end else if (phase == PH_MAIN) begin
          nxt = ST_CONF1;
        end else if (pollAtLimit) begin
          stb.setFail    = 1'b1;
          stb.setTimeout = 1'b1;
          nxt            = ST_DONE;
        end else begin
          nxt = ST_READ;
        end
      end
      ST_SETTLE: if (settleDone) begin
        if (isErase) begin
          stb.setPass = 1'b1;
          nxt         = ST_DONE;
        end else begin
          nxt = ST_VERIFY;
        end
      end
      ST_VERIFY: if (rdValid) begin
        if (verifyMatch) stb.setPass = 1'b1;
        else             stb.setFail = 1'b1;
        nxt = ST_DONE;
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign rdReq = (state == ST_READ) || (state == ST_CONF1) ||
                 (state == ST_CONF2) || (state == ST_VERIFY);
  assign done  = (state == ST_DONE);

endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int POLL_LIMIT    = 4096,
  parameter int SETTLE_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opErase,
  input  logic              useToggle,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [7:0]        rdData,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              timeout
);

  pollStrobe_t stb;
  logic ok, verifyMatch, pollAtLimit, settleDone, isErase;

  poll_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .rdValid     (rdValid),
    .ok          (ok),
    .verifyMatch (verifyMatch),
    .pollAtLimit (pollAtLimit),
    .settleDone  (settleDone),
    .isErase     (isErase),
    .stb         (stb),
    .rdReq       (rdReq),
    .done        (done)
  );

  poll_datapath #(
    .ADDR_W        (ADDR_W),
    .POLL_LIMIT    (POLL_LIMIT),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .addrIn      (addrIn),
    .dataIn      (dataIn),
    .opErase     (opErase),
    .useToggle   (useToggle),
    .rdData      (rdData),
    .rdAddr      (rdAddr),
    .ok          (ok),
    .verifyMatch (verifyMatch),
    .pollAtLimit (pollAtLimit),
    .settleDone  (settleDone),
    .isErase     (isErase),
    .pass        (pass),
    .fail        (fail),
    .timeout     (timeout)
  );

endmodule

// File: rtl/poll_checker.sv
module poll_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdValid,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic              timeout
);

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> rdReq);

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> $stable(rdAddr));

  assert_timeout_fails_R9: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> (fail && !pass));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_result_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pass ^ fail));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(pass) || !$stable(fail) || !$stable(timeout)) |-> (done || $past(start)));

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R11: assert (!done && !pass && !fail && !timeout);
    end
  end

endmodule

bind flash_status_poller poll_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .rdReq   (rdReq),
  .rdAddr  (rdAddr),
  .rdValid (rdValid),
  .done    (done),
  .pass    (pass),
  .fail    (fail),
  .timeout (timeout)
);

// File: tb/tb_flash_status_poller.sv
module tb_flash_status_poller;

  localparam int AW  = 12;
  localparam int LIM = 6;
  localparam int SET = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          opErase = 1'b0;
  logic          useToggle = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [7:0]    dataIn = '0;
  logic          rdReq;
  logic [AW-1:0] rdAddr;
  logic          rdValid = 1'b0;
  logic [7:0]    rdData = '0;
  logic          done, pass, fail, timeout;

  flash_status_poller #(.ADDR_W(AW), .POLL_LIMIT(LIM), .SETTLE_CYCLES(SET)) dut (
    .clk(clk), .rstN(rstN), .start(start), .opErase(opErase), .useToggle(useToggle),
    .addrIn(addrIn), .dataIn(dataIn), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .done(done), .pass(pass), .fail(fail),
    .timeout(timeout)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // device model configuration
  int            mB = 0, mPoll = 0, mLat = 0;
  bit            mErase = 0, mBad = 0;
  logic [7:0]    mExp = '0;
  logic [AW-1:0] mAddr = '0;
  int readIdx = 0, waitCnt = 0, addrErr = 0;
  int lastValidCyc = 0, reqCyc = 0, verifyGap = -1;

  task automatic check(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] finalByte();
    if (mErase) return 8'hFF;
    return mBad ? (mExp ^ 8'h01) : mExp;
  endfunction

  function automatic logic [7:0] model(input int idx);
    logic [7:0] f, b;
    f = finalByte();
    if (idx < mB) begin
      b[7]   = mErase ? 1'b0 : ~mExp[7];
      b[6]   = f[6] ^ (((mB - 1 - idx) % 2) == 0);
      b[5:0] = 6'(idx * 11 + 5);
    end else if (idx < mPoll) begin
      b = {f[7:6], f[5:0] ^ 6'h2A};
    end else begin
      b = f;
    end
    return b;
  endfunction

  // read responder: answers after mLat idle negedges, one pulse per request
  always @(negedge clk) begin
    cyc++;
    if (rdValid) begin
      rdValid = 1'b0;
    end else if (rdReq) begin
      if (waitCnt == 0) reqCyc = cyc;
      if (waitCnt >= mLat) begin
        rdValid = 1'b1;
        rdData  = model(readIdx);
        if (rdAddr !== mAddr) addrErr++;
        if (readIdx == mPoll) verifyGap = reqCyc - lastValidCyc;
        lastValidCyc = cyc;
        readIdx++;
        waitCnt = 0;
      end else begin
        waitCnt++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // expected outcome from the status rules
  function automatic bit readOk(input bit tog, input int j, input int b);
    return tog ? (j >= b + 1) : (j >= b);
  endfunction

  task automatic run(input bit tog, input bit er, input int b, input bit bad,
                     input int lat, input bit inject);
    int  polls;
    bit  expTo, expPass, complete;
    int  expReads;
    string tag;
    polls = 0; expTo = 0; complete = 0;
    for (int r = 1; r <= LIM && !complete && !expTo; r++) begin
      if (readOk(tog, polls, b)) begin
        polls++; complete = 1;
      end else begin
        polls++;
        if (readOk(tog, polls, b)) begin
          polls += 2; complete = 1;
        end else begin
          polls++;
          if (r == LIM) expTo = 1;
        end
      end
    end
    expPass  = !expTo && (er || !bad);
    expReads = polls + ((!er && !expTo) ? 1 : 0);
    tag = tog ? "R5/R6" : (er ? "R4/R6" : "R3/R6");

    mB = b; mPoll = polls; mLat = lat; mErase = er; mBad = bad;
    mExp = 8'h3C ^ 8'(b * 37) ^ (tog ? 8'h81 : 8'h00);
    mAddr = AW'(12'h5A0 + b * 3 + (tog ? 1 : 0));
    readIdx = 0; waitCnt = 0; addrErr = 0; verifyGap = -1;

    @(negedge clk);
    start = 1'b1; opErase = er; useToggle = tog; addrIn = mAddr; dataIn = mExp;
    @(negedge clk);
    start = 1'b0; opErase = ~er; useToggle = ~tog; addrIn = ~mAddr; dataIn = ~mExp;
    if (inject) begin
      while (readIdx < 1) @(negedge clk);
      start = 1'b1; dataIn = ~mExp;    // R1: must be ignored mid-run
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);

    check(readIdx == expReads, tag, readIdx, expReads);
    check(addrErr == 0, "R2", addrErr, 0);
    check(pass == expPass, expTo ? "R9" : "R8", pass, expPass);
    check(fail == !expPass, "R10", fail, !expPass);
    check(timeout == expTo, "R9", timeout, expTo);
    if (!er && !expTo)
      check(verifyGap == SET + 2, "R7", verifyGap, SET + 2);
    if (inject)
      check(pass == expPass && readIdx == expReads, "R1", readIdx, expReads);
    @(negedge clk);
    check(done == 1'b0, "R10", done, 0);
    @(negedge clk);
    check(pass == expPass && fail == !expPass, "R10", pass, expPass);
    check(rdReq == 1'b0, "R2", rdReq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!rdReq && !done && !pass && !fail && !timeout, "R11", rdReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!rdReq && !done && !pass && !fail && !timeout, "R11", done, 0);

    for (int tog = 0; tog < 2; tog++)
      for (int er = 0; er < 2; er++)
        for (int b = 0; b < 9; b++)
          run(tog[0], er[0], b, 1'b0, (b + er) % 3, 1'b0);

    run(1'b0, 1'b0, 40, 1'b0, 1, 1'b0);   // R9 timeout, inverted-MSB
    run(1'b1, 1'b1, 40, 1'b0, 0, 1'b0);   // R9 timeout, toggle
    run(1'b0, 1'b0, 0, 1'b1, 0, 1'b0);    // R8 verify mismatch
    run(1'b0, 1'b0, 3, 1'b1, 2, 1'b0);
    run(1'b1, 1'b0, 4, 1'b1, 1, 1'b0);
    run(1'b0, 1'b0, 5, 1'b0, 1, 1'b1);    // R1 start during run
    run(1'b1, 1'b1, 5, 1'b0, 2, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule